// File: doc/BRIEF.md
# Tagged Operand Address Generator

This block resolves the three operand fields of a fixed-format 64-bit three-address instruction (A = B op C) into values that an execution stage can use directly. Each operand field carries a 3-bit mode tag. A tag can make the field an immediate value, a scalar in the current routine's data area, or a reference to an array element through a packed descriptor word kept in that data area. Operand decoding never looks at the opcode. The opcode is only passed through to the result.

A caller pulses `start` with the instruction word and the physical base address of the data area. The block then works through the operands C, B and A in that order. It reads descriptors and index words through a single-outstanding request/response memory port. For each array reference it checks the element index against the array length and maps the virtual page through a 16-entry translation table held inside the block. When it finishes, it pulses `done` for one cycle. At that point either all three results are valid, or a single fault code names the first check that failed. No operand after the faulting one is processed.

Software fills the translation table through a write port. After reset every entry reads as absent.

Top module: `opnd_resolver`

## Requirements
- R1: Instruction layout. Operand A is bits [15:0], B is bits [31:16] and C is bits [47:32]. The tags sit in bits [56:48], with A's tag in [50:48], B's in [53:51] and C's in [56:54]. This makes the 9-bit value equal to tagC*64 + tagB*8 + tagA. The opcode is bits [63:57] and is forwarded on `opcode`.
- R2: Tag 1 gives an immediate. The operand value is the 16-bit field, zero-extended, and the operand's `op_imm` bit (bit 0 = A, bit 1 = B, bit 2 = C) is set.
- R3: Tag 2 gives a local scalar. The operand value is `data_base` plus the field, taken modulo 2^24, and its `op_imm` bit is clear.
- R4: Tag 3 reads a descriptor from address `data_base` + field.
  - The descriptor's fields are: kind in [63:58], virtual page in [57:48], word in [47:32], length in [31:16] and index in [15:0].
  - Kind 0 reads the index value J from `data_base` + index.
  - Kind 1 takes J as the index field itself, zero-extended.
  - Any other kind ends the decode with fault code 4.
- R5: J is treated as a signed 64-bit number. If J < 1 or J > length, the decode ends with fault code 2. A length of 0 therefore always faults.
- R6: The linear virtual address is page*4096 + word + J - 1. Its bits [11:0] are the page offset, and the bits above them are the virtual page number.
  - The decode ends with fault code 3 if that page is 16 or higher, or if its table entry has bit 24 set (negative).
  - Otherwise the operand value is entry[23:0] + offset, modulo 2^24.
  - A bounds fault takes precedence over a page fault.
- R7: Tag values 0, 4, 5, 6 and 7 end the decode with fault code 1.
- R8: Operand order and early stop.
  - Operands are resolved in the order C, B, A.
  - Processing stops at the first fault, so no memory read is made for a later operand.
  - `fault_code` is 0 exactly when all three results are valid, and its only values are 0 to 4.
  - The number of memory reads is one per tag-3 operand reached, plus one more when its kind is 0.
- R9: After reset all 16 table entries are absent. A write with `pt_we` high stores `pt_entry` at `pt_idx`, and later decodes use the new value.
- R10: `start` is ignored while a decode is in progress. `done` lasts exactly one cycle. `mem_req` stays high with `mem_addr` unchanged until a cycle with `mem_rvalid` high.
- R11: During and right after reset, `done`, `mem_req`, `fault_code` and `op_imm` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin decoding `instr`; taken only when idle |
| instr | input | 64 | Instruction word |
| data_base | input | 24 | Physical word address of the data area |
| pt_we | input | 1 | Translation table write enable |
| pt_idx | input | 4 | Table entry to write |
| pt_entry | input | 25 | Entry value; bit 24 set means page absent |
| mem_req | output | 1 | Memory read request, held until accepted |
| mem_addr | output | 24 | Word address of the read |
| mem_rvalid | input | 1 | Read data valid; completes the request |
| mem_rdata | input | 64 | Read data |
| done | output | 1 | One-cycle completion pulse |
| fault_code | output | 3 | 0 none, 1 illegal tag, 2 bounds, 3 page, 4 descriptor kind |
| opcode | output | 7 | Opcode forwarded from the instruction |
| op_imm | output | 3 | Per operand: value is an immediate |
| op_val_a | output | 24 | Operand A value or physical address |
| op_val_b | output | 24 | Operand B value or physical address |
| op_val_c | output | 24 | Operand C value or physical address |

## Verification
The assertions check the handshake rules on every cycle:
- `done` is a single-cycle pulse.
- A pending read keeps its request and address until it is accepted.
- No read is outstanding when `done` is high.
- The fault code is always one of the five legal values.
- An immediate result carries no bits above its 16-bit field.

The correctness of the computed addresses can only be shown by the bench's scenarios. These include bounds edges, offsets that carry into the next page, absent pages, and the choice of which operand faults first. The same holds for the count of memory reads that proves processing stopped early, and for the effect of table writes.

// File: rtl/opr_pkg.sv
package opr_pkg;

    localparam int INSTR_W  = 64;
    localparam int FIELD_W  = 16;
    localparam int TAG_W    = 3;
    localparam int NUM_OPS  = 3;
    localparam int TAG_LSB  = NUM_OPS * FIELD_W;
    localparam int OPC_LSB  = TAG_LSB + NUM_OPS * TAG_W;
    localparam int OPC_W    = INSTR_W - OPC_LSB;
    localparam int KIND_W   = 6;
    localparam int DPAGE_W  = INSTR_W - KIND_W - 3 * FIELD_W;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_TAG    = 3'd1,
        FLT_BOUNDS = 3'd2,
        FLT_PAGE   = 3'd3,
        FLT_KIND   = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        MODE_IMM,
        MODE_LOCAL,
        MODE_INDIR,
        MODE_BAD
    } mode_e;

    typedef struct packed {
        logic [KIND_W-1:0]  kind;
        logic [DPAGE_W-1:0] page;
        logic [FIELD_W-1:0] word;
        logic [FIELD_W-1:0] len;
        logic [FIELD_W-1:0] idx;
    } desc_t;

    localparam logic [KIND_W-1:0] KIND_VAR   = 6'd0;
    localparam logic [KIND_W-1:0] KIND_CONST = 6'd1;

    function automatic mode_e tag_mode(input logic [TAG_W-1:0] t);
        case (t)
            3'd1:    return MODE_IMM;
            3'd2:    return MODE_LOCAL;
            3'd3:    return MODE_INDIR;
            default: return MODE_BAD;
        endcase
    endfunction

    function automatic logic [TAG_W-1:0] tag_of(input logic [NUM_OPS*TAG_W-1:0] grp,
                                                input int k);
        return grp[k*TAG_W +: TAG_W];
    endfunction

endpackage

// File: rtl/opr_page_table.sv
module opr_page_table #(
    parameter int DEPTH   = 16,
    parameter int IDX_W   = $clog2(DEPTH),
    parameter int ENTRY_W = 25,
    parameter int VP_W    = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic [VP_W-1:0]    rd_page,
    output logic               rd_absent,
    output logic [ENTRY_W-2:0] rd_base
);

    localparam logic [ENTRY_W-1:0] ABSENT = {1'b1, {(ENTRY_W-1){1'b0}}};

    logic [ENTRY_W-1:0] rows [DEPTH];

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_row
            always_ff @(posedge clk) begin
                if (rst) begin
                    rows[g] <= ABSENT;
                end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                    rows[g] <= wr_data;
                end
            end
        end
    endgenerate

    logic               in_range;
    logic [ENTRY_W-1:0] sel;

    always_comb begin
        in_range  = (rd_page < VP_W'(DEPTH));
        sel       = rows[rd_page[IDX_W-1:0]];
        rd_absent = !in_range || sel[ENTRY_W-1];
        rd_base   = sel[ENTRY_W-2:0];
    end

endmodule

// File: rtl/opr_index_xlate.sv
module opr_index_xlate
    import opr_pkg::*;
#(
    parameter int PAGE_BITS = 12,
    parameter int LIN_W     = DPAGE_W + PAGE_BITS + 1,
    parameter int VP_W      = LIN_W - PAGE_BITS
) (
    input  desc_t                desc,
    input  logic [INSTR_W-1:0]   j_val,
    output logic                 bounds_bad,
    output logic [VP_W-1:0]      vpage,
    output logic [PAGE_BITS-1:0] offset
);

    logic [FIELD_W-1:0] j_minus1;
    logic [LIN_W-1:0]   lin;
    logic               too_low;
    logic               too_high;

    always_comb begin
        too_low    = $signed(j_val) < 64'sd1;
        too_high   = $signed(j_val) > $signed({{(INSTR_W-FIELD_W){1'b0}}, desc.len});
        bounds_bad = too_low || too_high;
        j_minus1   = j_val[FIELD_W-1:0] - 16'd1;
        lin        = LIN_W'({desc.page, {PAGE_BITS{1'b0}}})
                   + LIN_W'(desc.word)
                   + LIN_W'(j_minus1);
        vpage      = lin[LIN_W-1:PAGE_BITS];
        offset     = lin[PAGE_BITS-1:0];
    end

endmodule

// File: rtl/opr_seq.sv
module opr_seq
    import opr_pkg::*;
#(
    parameter int PADDR_W   = 24,
    parameter int PAGE_BITS = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [INSTR_W-1:0]   instr,
    input  logic [PADDR_W-1:0]   data_base,
    output logic                 mem_req,
    output logic [PADDR_W-1:0]   mem_addr,
    input  logic                 mem_rvalid,
    input  logic [INSTR_W-1:0]   mem_rdata,
    output desc_t                desc_o,
    output logic [INSTR_W-1:0]   j_o,
    input  logic                 bounds_bad,
    input  logic                 pt_absent,
    input  logic [PADDR_W-1:0]   pt_base,
    input  logic [PAGE_BITS-1:0] offset,
    output logic                 done,
    output logic [2:0]           fault_code,
    output logic [OPC_W-1:0]     opcode,
    output logic [NUM_OPS-1:0]   op_imm,
    output logic [PADDR_W-1:0]   op_val_a,
    output logic [PADDR_W-1:0]   op_val_b,
    output logic [PADDR_W-1:0]   op_val_c
);

    typedef enum logic [2:0] {
        S_IDLE,
        S_OPER,
        S_DESC,
        S_IDX,
        S_XL,
        S_DONE
    } state_e;

    state_e                       state;
    logic [NUM_OPS*FIELD_W-1:0]   fields_q;
    mode_e                        mode_q [NUM_OPS];
    logic [PADDR_W-1:0]           base_q;
    logic [1:0]                   cur;
    desc_t                        desc_q;
    logic [INSTR_W-1:0]           j_q;
    fault_e                       fault_q;
    logic [PADDR_W-1:0]           val_q [NUM_OPS];
    logic [NUM_OPS-1:0]           imm_q;
    logic [OPC_W-1:0]             opc_q;

    logic [FIELD_W-1:0]           cur_field;
    mode_e                        cur_mode;
    logic [PADDR_W-1:0]           local_addr;
    logic [PADDR_W-1:0]           idx_addr;
    desc_t                        rd_desc;
    logic                         last_op;

    always_comb begin
        cur_field  = fields_q[int'(cur)*FIELD_W +: FIELD_W];
        cur_mode   = mode_q[cur];
        local_addr = base_q + PADDR_W'(cur_field);
        idx_addr   = base_q + PADDR_W'(desc_q.idx);
        rd_desc    = desc_t'(mem_rdata);
        last_op    = (cur == 2'd0);
        mem_req    = (state == S_DESC) || (state == S_IDX);
        mem_addr   = (state == S_IDX) ? idx_addr : local_addr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            fields_q <= '0;
            base_q   <= '0;
            cur      <= 2'd0;
            desc_q   <= '0;
            j_q      <= '0;
            fault_q  <= FLT_NONE;
            imm_q    <= '0;
            opc_q    <= '0;
            for (int k = 0; k < NUM_OPS; k++) begin
                mode_q[k] <= MODE_BAD;
                val_q[k]  <= '0;
            end
        end else begin
            case (state)
                S_IDLE: begin
                    if (start) begin
                        fields_q <= instr[TAG_LSB-1:0];
                        opc_q    <= instr[INSTR_W-1:OPC_LSB];
                        base_q   <= data_base;
                        cur      <= 2'(NUM_OPS - 1);
                        fault_q  <= FLT_NONE;
                        imm_q    <= '0;
                        for (int k = 0; k < NUM_OPS; k++) begin
                            mode_q[k] <= tag_mode(tag_of(instr[OPC_LSB-1:TAG_LSB], k));
                            val_q[k]  <= '0;
                        end
                        state <= S_OPER;
                    end
                end
                S_OPER: begin
                    case (cur_mode)
                        MODE_IMM, MODE_LOCAL: begin
                            if (cur_mode == MODE_IMM) begin
                                val_q[cur] <= PADDR_W'(cur_field);
                                imm_q[cur] <= 1'b1;
                            end else begin
                                val_q[cur] <= local_addr;
                            end
                            if (last_op) begin
                                state <= S_DONE;
                            end else begin
                                cur <= cur - 2'd1;
                            end
                        end
                        MODE_INDIR: state <= S_DESC;
                        default: begin
                            fault_q <= FLT_TAG;
                            state   <= S_DONE;
                        end
                    endcase
                end
                S_DESC: begin
                    if (mem_rvalid) begin
                        desc_q <= rd_desc;
                        if (rd_desc.kind == KIND_VAR) begin
                            state <= S_IDX;
                        end else if (rd_desc.kind == KIND_CONST) begin
                            j_q   <= INSTR_W'(rd_desc.idx);
                            state <= S_XL;
                        end else begin
                            fault_q <= FLT_KIND;
                            state   <= S_DONE;
                        end
                    end
                end
                S_IDX: begin
                    if (mem_rvalid) begin
                        j_q   <= mem_rdata;
                        state <= S_XL;
                    end
                end
                S_XL: begin
                    if (bounds_bad) begin
                        fault_q <= FLT_BOUNDS;
                        state   <= S_DONE;
                    end else if (pt_absent) begin
                        fault_q <= FLT_PAGE;
                        state   <= S_DONE;
                    end else begin
                        val_q[cur] <= pt_base + PADDR_W'(offset);
                        if (last_op) begin
                            state <= S_DONE;
                        end else begin
                            cur   <= cur - 2'd1;
                            state <= S_OPER;
                        end
                    end
                end
                S_DONE:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign desc_o     = desc_q;
    assign j_o        = j_q;
    assign done       = (state == S_DONE);
    assign fault_code = fault_q;
    assign opcode     = opc_q;
    assign op_imm     = imm_q;
    assign op_val_a   = val_q[0];
    assign op_val_b   = val_q[1];
    assign op_val_c   = val_q[2];

endmodule

// File: rtl/opnd_resolver.sv
module opnd_resolver
    import opr_pkg::*;
#(
    parameter int PADDR_W   = 24,
    parameter int PAGE_BITS = 12,
    parameter int PT_DEPTH  = 16,
    parameter int PT_IDX_W  = $clog2(PT_DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [63:0]          instr,
    input  logic [PADDR_W-1:0]   data_base,
    input  logic                 pt_we,
    input  logic [PT_IDX_W-1:0]  pt_idx,
    input  logic [PADDR_W:0]     pt_entry,
    output logic                 mem_req,
    output logic [PADDR_W-1:0]   mem_addr,
    input  logic                 mem_rvalid,
    input  logic [63:0]          mem_rdata,
    output logic                 done,
    output logic [2:0]           fault_code,
    output logic [6:0]           opcode,
    output logic [2:0]           op_imm,
    output logic [PADDR_W-1:0]   op_val_a,
    output logic [PADDR_W-1:0]   op_val_b,
    output logic [PADDR_W-1:0]   op_val_c
);

    localparam int LIN_W   = DPAGE_W + PAGE_BITS + 1;
    localparam int VP_W    = LIN_W - PAGE_BITS;
    localparam int ENTRY_W = PADDR_W + 1;

    desc_t                desc;
    logic [63:0]          j_val;
    logic                 bounds_bad;
    logic [VP_W-1:0]      vpage;
    logic [PAGE_BITS-1:0] offset;
    logic                 pt_absent;
    logic [PADDR_W-1:0]   pt_base;

    opr_seq #(
        .PADDR_W   (PADDR_W),
        .PAGE_BITS (PAGE_BITS)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .instr      (instr),
        .data_base  (data_base),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .desc_o     (desc),
        .j_o        (j_val),
        .bounds_bad (bounds_bad),
        .pt_absent  (pt_absent),
        .pt_base    (pt_base),
        .offset     (offset),
        .done       (done),
        .fault_code (fault_code),
        .opcode     (opcode),
        .op_imm     (op_imm),
        .op_val_a   (op_val_a),
        .op_val_b   (op_val_b),
        .op_val_c   (op_val_c)
    );

    opr_index_xlate #(
        .PAGE_BITS (PAGE_BITS),
        .LIN_W     (LIN_W),
        .VP_W      (VP_W)
    ) u_xlate (
        .desc       (desc),
        .j_val      (j_val),
        .bounds_bad (bounds_bad),
        .vpage      (vpage),
        .offset     (offset)
    );

    opr_page_table #(
        .DEPTH   (PT_DEPTH),
        .IDX_W   (PT_IDX_W),
        .ENTRY_W (ENTRY_W),
        .VP_W    (VP_W)
    ) u_pt (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (pt_we),
        .wr_idx    (pt_idx),
        .wr_data   (pt_entry),
        .rd_page   (vpage),
        .rd_absent (pt_absent),
        .rd_base   (pt_base)
    );

endmodule

// File: rtl/opnd_resolver_chk.sv
module opnd_resolver_chk #(
    parameter int PADDR_W = 24
) (
    input logic               clk,
    input logic               rst,
    input logic               done,
    input logic               mem_req,
    input logic               mem_rvalid,
    input logic [PADDR_W-1:0] mem_addr,
    input logic [2:0]         fault_code,
    input logic [2:0]         op_imm,
    input logic [PADDR_W-1:0] op_val_a
);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr))); // R10

    AST_DONE_NO_READ: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_req); // R8

    AST_FAULT_LEGAL: assert property (@(posedge clk) disable iff (rst)
        done |-> (fault_code <= 3'd4)); // R8

    AST_IMM_NARROW: assert property (@(posedge clk) disable iff (rst)
        (done && fault_code == 3'd0 && op_imm[0]) |-> (op_val_a[PADDR_W-1:16] == '0)); // R2

endmodule

bind opnd_resolver opnd_resolver_chk #(.PADDR_W(PADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .done       (done),
    .mem_req    (mem_req),
    .mem_rvalid (mem_rvalid),
    .mem_addr   (mem_addr),
    .fault_code (fault_code),
    .op_imm     (op_imm),
    .op_val_a   (op_val_a)
);

// File: tb/opnd_resolver_test.sv
module opnd_resolver_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [63:0] instr;
    logic [23:0] data_base;
    logic        pt_we;
    logic [3:0]  pt_idx;
    logic [24:0] pt_entry;
    logic        mem_req;
    logic [23:0] mem_addr;
    logic        mem_rvalid;
    logic [63:0] mem_rdata;
    logic        done;
    logic [2:0]  fault_code;
    logic [6:0]  opcode;
    logic [2:0]  op_imm;
    logic [23:0] op_val_a, op_val_b, op_val_c;

    opnd_resolver uut (
        .clk(clk), .rst(rst), .start(start), .instr(instr), .data_base(data_base),
        .pt_we(pt_we), .pt_idx(pt_idx), .pt_entry(pt_entry),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .done(done), .fault_code(fault_code), .opcode(opcode), .op_imm(op_imm),
        .op_val_a(op_val_a), .op_val_b(op_val_b), .op_val_c(op_val_c)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int rd_count = 0;
    int lat = 0;

    logic [63:0] mem [int];
    logic [24:0] pt_m [16];

    logic [2:0]  exp_f;
    logic [23:0] exp_v [3];
    logic [2:0]  exp_i;
    logic [2:0]  exp_tag [3];
    int          exp_r;

    function automatic logic [63:0] rd(input int a);
        return mem.exists(a) ? mem[a] : 64'd0;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    function automatic string flt_req(input logic [2:0] f);
        case (f)
            3'd1: return "R7";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R4";
            default: return "R8";
        endcase
    endfunction

    function automatic string tag_req(input logic [2:0] t);
        case (t)
            3'd1: return "R2";
            3'd2: return "R3";
            default: return "R6";
        endcase
    endfunction

    // Reference model built from the requirements
    task automatic model(input logic [63:0] ins, input logic [23:0] b);
        logic [15:0] fld;
        logic [2:0]  tg;
        logic [63:0] d;
        logic [63:0] j;
        logic [23:0] a;
        int          lin;
        int          vp;
        int          off;
        exp_f = 3'd0;
        exp_i = 3'd0;
        exp_r = 0;
        for (int k = 0; k < 3; k++) begin
            exp_v[k]   = 24'd0;
            exp_tag[k] = ins[48 + 3*k +: 3];
        end
        for (int k = 2; k >= 0; k--) begin
            fld = ins[16*k +: 16];
            tg  = ins[48 + 3*k +: 3];
            if (tg == 3'd1) begin
                exp_v[k] = {8'd0, fld};
                exp_i[k] = 1'b1;
            end else if (tg == 3'd2) begin
                exp_v[k] = b + {8'd0, fld};
            end else if (tg == 3'd3) begin
                a = b + {8'd0, fld};
                d = rd(int'(a));
                exp_r++;
                if (d[63:58] == 6'd0) begin
                    a = b + {8'd0, d[15:0]};
                    j = rd(int'(a));
                    exp_r++;
                end else if (d[63:58] == 6'd1) begin
                    j = {48'd0, d[15:0]};
                end else begin
                    exp_f = 3'd4;
                    return;
                end
                if ($signed(j) < 64'sd1 || $signed(j) > $signed({48'd0, d[31:16]})) begin
                    exp_f = 3'd2;
                    return;
                end
                lin = int'(d[57:48]) * 4096 + int'(d[47:32]) + int'(j[15:0]) - 1;
                vp  = lin >> 12;
                off = lin & 4095;
                if (vp >= 16 || pt_m[vp][24]) begin
                    exp_f = 3'd3;
                    return;
                end
                exp_v[k] = pt_m[vp][23:0] + 24'(off);
            end else begin
                exp_f = 3'd1;
                return;
            end
        end
    endtask

    // Memory responder: random latency 0..2 extra cycles
    initial begin
        mem_rvalid = 1'b0;
        mem_rdata  = 64'd0;
        forever begin
            @(negedge clk);
            if (mem_rvalid) begin
                mem_rvalid = 1'b0;
            end else if (mem_req) begin
                if (lat == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = rd(int'(mem_addr));
                    rd_count++;
                    lat = int'($urandom % 3);
                end else begin
                    lat--;
                end
            end
        end
    end

    task automatic pt_write(input int i, input logic [24:0] e);
        @(negedge clk);
        pt_we    = 1'b1;
        pt_idx   = 4'(i);
        pt_entry = e;
        pt_m[i]  = e;
        @(negedge clk);
        pt_we    = 1'b0;
    endtask

    task automatic run_case(input logic [63:0] ins, input logic [23:0] b, input bit poke);
        int t;
        model(ins, b);
        rd_count = 0;
        @(negedge clk);
        start     = 1'b1;
        instr     = ins;
        data_base = b;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R10: a second start while busy must be ignored
            @(negedge clk);
            start     = 1'b1;
            instr     = ~ins;
            data_base = b + 24'd7;
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (!done && t < 400) begin
            @(negedge clk);
            t++;
        end
        chk(done === 1'b1, "R10", "done seen", {63'd0, done}, 64'd1);
        chk(fault_code === exp_f, flt_req(exp_f), "fault code", {61'd0, fault_code}, {61'd0, exp_f});
        chk(rd_count == exp_r, "R8", "memory reads", 64'(rd_count), 64'(exp_r));
        if (exp_f == 3'd0) begin
            chk(op_val_c === exp_v[2], tag_req(exp_tag[2]), "operand C", {40'd0, op_val_c}, {40'd0, exp_v[2]});
            chk(op_val_b === exp_v[1], tag_req(exp_tag[1]), "operand B", {40'd0, op_val_b}, {40'd0, exp_v[1]});
            chk(op_val_a === exp_v[0], tag_req(exp_tag[0]), "operand A", {40'd0, op_val_a}, {40'd0, exp_v[0]});
            chk(op_imm === exp_i, "R2", "imm flags", {61'd0, op_imm}, {61'd0, exp_i});
            chk(opcode === ins[63:57], "R1", "opcode", {57'd0, opcode}, {57'd0, ins[63:57]});
        end
        @(negedge clk);
        chk(done === 1'b0, "R10", "done one cycle", {63'd0, done}, 64'd0);
    endtask

    function automatic logic [63:0] mk_ins(input logic [6:0] opc,
                                           input logic [2:0] tc, input logic [2:0] tb, input logic [2:0] ta,
                                           input logic [15:0] fc, input logic [15:0] fb, input logic [15:0] fa);
        return {opc, tc, tb, ta, fc, fb, fa};
    endfunction

    function automatic logic [63:0] mk_desc(input logic [5:0] kind, input logic [9:0] page,
                                            input logic [15:0] word, input logic [15:0] len,
                                            input logic [15:0] idx);
        return {kind, page, word, len, idx};
    endfunction

    function automatic logic [2:0] pick_tag();
        int r;
        r = int'($urandom % 16);
        if (r < 4) return 3'd1;
        if (r < 8) return 3'd2;
        if (r < 15) return 3'd3;
        case ($urandom % 5)
            0: return 3'd0;
            1: return 3'd4;
            2: return 3'd5;
            3: return 3'd6;
            default: return 3'd7;
        endcase
    endfunction

    task automatic build_operand(input logic [23:0] b, input logic [2:0] tg, output logic [15:0] fld);
        logic [5:0]  kind;
        logic [15:0] len;
        logic [63:0] j;
        logic [15:0] ptr;
        int          r;
        fld = 16'($urandom % 256);
        if (tg != 3'd3) begin
            if (tg == 3'd1) fld = 16'($urandom);
            return;
        end
        r    = int'($urandom % 10);
        kind = (r < 5) ? 6'd0 : ((r < 9) ? 6'd1 : 6'd7);
        len  = ($urandom % 20 == 0) ? 16'd0 : 16'(1 + $urandom % 64);
        case ($urandom % 8)
            0: j = 64'd0;
            1: j = {48'd0, len} + 64'd1;
            2: j = 64'hFFFF_FFFF_FFFF_FFFD;
            3: j = {48'd0, len};
            default: j = (len == 0) ? 64'd1 : 64'(1 + $urandom % int'(len));
        endcase
        ptr = 16'(300 + $urandom % 200);
        if (kind == 6'd0) begin
            mem[int'(b + {8'd0, ptr})] = j;
        end else begin
            ptr = j[15:0];
        end
        mem[int'(b + {8'd0, fld})] = mk_desc(kind, 10'($urandom % 20), 16'($urandom % 4096), len, ptr);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R10 watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [63:0] ins;
        logic [23:0] b;
        logic [15:0] fa, fb, fc;
        logic [2:0]  ta, tb, tc;
        void'($urandom(32'd1234));
        rst = 1'b1; start = 1'b0; instr = 64'd0; data_base = 24'd0;
        pt_we = 1'b0; pt_idx = 4'd0; pt_entry = 25'd0;
        for (int i = 0; i < 16; i++) pt_m[i] = 25'h100_0000;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(done === 1'b0, "R11", "done in reset", {63'd0, done}, 64'd0);
        chk(mem_req === 1'b0, "R11", "mem_req in reset", {63'd0, mem_req}, 64'd0);
        chk(fault_code === 3'd0, "R11", "fault in reset", {61'd0, fault_code}, 64'd0);
        chk(op_imm === 3'd0, "R11", "imm in reset", {61'd0, op_imm}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(done === 1'b0 && mem_req === 1'b0, "R11", "idle after reset", {62'd0, done, mem_req}, 64'd0);

        // Worked example: tags C=1 B=2 A=3 (index 83), element 25 of array at 5:862
        b = 24'h001000;
        mem[int'(b + 24'd316)] = mk_desc(6'd0, 10'd5, 16'd862, 16'd100, 16'd541);
        mem[int'(b + 24'd541)] = 64'd25;
        ins = mk_ins(7'h06, 3'd1, 3'd2, 3'd3, 16'd11, 16'd257, 16'd316);
        // R9: table starts absent, so this must page-fault
        run_case(ins, b, 1'b0);
        chk(fault_code === 3'd3, "R9", "reset table absent", {61'd0, fault_code}, 64'd3);
        pt_write(5, 25'h002_0000);
        run_case(ins, b, 1'b0);
        chk(op_val_a === 24'h020000 + 24'd886, "R1", "index 83 operand A", {40'd0, op_val_a}, 64'h020376);
        chk(op_val_b === 24'h001101 && op_val_c === 24'd11, "R9", "after table write",
            {16'd0, op_val_b, op_val_c}, {16'd0, 24'h001101, 24'd11});

        // R6: offset carry into the next page
        pt_write(6, 25'h003_0000);
        mem[int'(b + 24'd20)] = mk_desc(6'd1, 10'd5, 16'd4090, 16'd50, 16'd10);
        run_case(mk_ins(7'h01, 3'd2, 3'd2, 3'd3, 16'd1, 16'd2, 16'd20), b, 1'b0);
        chk(op_val_a === 24'h030003, "R6", "page carry", {40'd0, op_val_a}, 64'h030003);

        // R5: bounds edges
        mem[int'(b + 24'd30)] = mk_desc(6'd1, 10'd5, 16'd0, 16'd40, 16'd40);
        run_case(mk_ins(7'h02, 3'd1, 3'd1, 3'd3, 16'd1, 16'd2, 16'd30), b, 1'b0);
        mem[int'(b + 24'd30)] = mk_desc(6'd1, 10'd5, 16'd0, 16'd40, 16'd41);
        run_case(mk_ins(7'h02, 3'd1, 3'd1, 3'd3, 16'd1, 16'd2, 16'd30), b, 1'b0);
        mem[int'(b + 24'd30)] = mk_desc(6'd1, 10'd5, 16'd0, 16'd0, 16'd1);
        run_case(mk_ins(7'h02, 3'd1, 3'd1, 3'd3, 16'd1, 16'd2, 16'd30), b, 1'b0);
        // R5 over R6: out of bounds on an absent page reports bounds
        mem[int'(b + 24'd30)] = mk_desc(6'd1, 10'd9, 16'd0, 16'd4, 16'd0);
        run_case(mk_ins(7'h02, 3'd1, 3'd1, 3'd3, 16'd1, 16'd2, 16'd30), b, 1'b0);

        // R4: unsupported descriptor kind
        mem[int'(b + 24'd40)] = mk_desc(6'd2, 10'd5, 16'd0, 16'd4, 16'd1);
        run_case(mk_ins(7'h03, 3'd3, 3'd1, 3'd1, 16'd40, 16'd2, 16'd3), b, 1'b0);

        // R7 and R8: illegal B tag after an indirect C; A indirect never read
        mem[int'(b + 24'd50)] = mk_desc(6'd0, 10'd5, 16'd0, 16'd100, 16'd541);
        run_case(mk_ins(7'h04, 3'd3, 3'd5, 3'd3, 16'd50, 16'd2, 16'd50), b, 1'b0);
        run_case(mk_ins(7'h04, 3'd0, 3'd3, 3'd3, 16'd50, 16'd50, 16'd50), b, 1'b0);

        // R10: start while busy ignored
        run_case(mk_ins(7'h05, 3'd3, 3'd2, 3'd1, 16'd50, 16'd9, 16'd77), b, 1'b1);

        // Random mix
        for (int n = 0; n < 300; n++) begin
            if (n % 50 == 0) begin
                for (int i = 0; i < 16; i++) begin
                    if ($urandom % 4 == 0) pt_write(i, {1'b1, 24'($urandom)});
                    else pt_write(i, {1'b0, 24'($urandom)});
                end
            end
            mem.delete();
            b  = 24'h000100 + 24'($urandom % 4096);
            tc = pick_tag();
            tb = pick_tag();
            ta = pick_tag();
            build_operand(b, tc, fc);
            build_operand(b, tb, fb);
            build_operand(b, ta, fa);
            run_case(mk_ins(7'($urandom), tc, tb, ta, fc, fb, fa), b, (n % 25 == 0) && (tc == 3'd3));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule